// File: doc/BRIEF.md
# Nested-Priority Interrupt Delivery Unit

This block is the delivery stage that sits in front of one processor in a multiprocessor interrupt controller. Each source presents a request line, a 4-bit priority, a vector number and a flag that selects edge or level sensing. The unit keeps a raised set (sources whose request is currently pending) and an in-service set (sources the processor has taken but not yet retired). It drives a single interrupt line to the processor.

Interrupts nest by priority. A source can interrupt the processor only when its priority is above the task priority and above every source already in service. Software reads an acknowledge register to obtain the vector and move the source into service. It writes an end-of-interrupt register to retire the highest-priority source in service, and it writes a task priority register to raise or lower the blocking threshold. Edge-sensed sources are consumed by acknowledge. Level-sensed sources remain raised for as long as their request line is high.

Top module: `irq_delivery_unit`

## Requirements
- R1: The best member of the raised set, and of the in-service set, is the one with the highest priority under a strict greater-than comparison, so among equal priorities the lowest source index wins.
- R2: `irq_out` is a registered output. It is high one cycle after the best raised priority exceeds the task priority and either nothing is in service or the best raised priority exceeds the best in-service priority. Equal or lower priorities than the one in service are blocked.
- R3: The task priority register is at byte offset 0x80. A write keeps only bits [3:0] of the write data, a read returns it zero-extended, and it resets to 15, so every source is blocked after reset.
- R4: A read at offset 0xA0 (acknowledge) returns the zero-extended vector of the best raised source and adds that source to the in-service set. `irq_out` is low in the cycle after the acknowledge read.
- R5: If nothing is raised, or the best raised priority does not exceed the task priority, an acknowledge read returns the spurious vector (all ones within the vector width) and leaves the in-service set unchanged.
- R6: For an edge source (`src_edge` bit = 1), a 0-to-1 transition of its request is latched as pending, and an acknowledge of that source clears it. A level source (`src_edge` bit = 0) is raised exactly while its request is high, including after acknowledge.
- R7: A write at offset 0xB0 (end of interrupt) removes the highest-priority member of the in-service set (by R1). The output then follows R2 with the reduced set. A write with an empty set has no effect.
- R8: A write to the task priority register re-evaluates `irq_out`. It falls when the best raised priority is no longer above the new value and rises when the raised source beats the in-service priority.
- R9: An access whose address bits [3:0] are not zero is ignored. Such a read returns 0xFFFFFFFF. A read of the end-of-interrupt offset returns 0, and a read of any other unmapped aligned offset returns 0xFFFFFFFF.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Request line per source |
| src_edge | input | NUM_SRC | 1 = edge-sensed source, 0 = level-sensed |
| src_prio | input | NUM_SRC*4 | Priority per source, source i at bits [4i+3:4i] |
| src_vec | input | NUM_SRC*VEC_W | Vector per source, source i at slice i |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the unit with eight sources, an 8-bit vector and a 12-bit address. With eight sources, a handful of request patterns reach ties between sources, two-deep nesting, and retirement order with both a level and an edge source in flight. The 8-bit vector makes the spurious value 0xFF, so it cannot be mistaken for any real vector the bench assigns (0x40 plus the source index). The task priority is swept across values that sit just below, equal to and above the raised priority, which exercises both strictness boundaries of the delivery rule.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int PRIO_W  = 4;
    localparam int DATA_W  = 32;
    localparam int OFS_TPR = 'h80;
    localparam int OFS_ACK = 'hA0;
    localparam int OFS_EOI = 'hB0;

    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irqd_prio_select.sv
module irqd_prio_select
    import irqd_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        member,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IDX_W-1:0]    idx,
    output prio_t               best
);
    // Scan upward; strict greater-than keeps the lowest index on ties (R1)
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (member[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqd_src_capture.sv
module irqd_src_capture #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] is_edge,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] raised
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] prev;
    } cap_t;

    cap_t st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        rise      = req & ~st_q.prev & is_edge;
        st_d.prev = req;
        // a fresh edge in the acknowledge cycle survives the clear
        st_d.pend = (st_q.pend & ~ack_clr) | rise;
        raised    = (is_edge & st_q.pend) | (~is_edge & req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            (is_edge[g] && req[g] && !st_q.prev[g]) |=> st_q.pend[g]); // R6
        AST_ACK_CONSUMES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[g] && !(req[g] && !st_q.prev[g])) |=> !st_q.pend[g]); // R6
    end
endmodule

// File: rtl/irq_delivery_unit.sv
module irq_delivery_unit
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int VEC_W   = 16,
    parameter int ADDR_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_req,
    input  logic [NUM_SRC-1:0]         src_edge,
    input  logic [NUM_SRC*PRIO_W-1:0]  src_prio,
    input  logic [NUM_SRC*VEC_W-1:0]   src_vec,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       irq_out
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [VEC_W-1:0] SPURIOUS = {VEC_W{1'b1}};

    typedef struct packed {
        prio_t              tpr;
        logic [NUM_SRC-1:0] service;
        logic [DATA_W-1:0]  rdata;
        logic               irq;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NUM_SRC-1:0] raised, ack_clr;
    logic               rs_found, sv_found;
    logic [IDX_W-1:0]   rs_idx, sv_idx;
    prio_t              rs_best, sv_best;

    logic aligned, hit_tpr, hit_ack, hit_eoi;
    logic ack_rd, ack_ok, eoi_wr, tpr_wr;
    logic [VEC_W-1:0] rs_vec;

    irqd_src_capture #(.N(NUM_SRC)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_req),
        .is_edge (src_edge),
        .ack_clr (ack_clr),
        .raised  (raised)
    );

    irqd_prio_select #(.N(NUM_SRC), .IDX_W(IDX_W)) u_sel_raised (
        .member    (raised),
        .prio_flat (src_prio),
        .found     (rs_found),
        .idx       (rs_idx),
        .best      (rs_best)
    );

    irqd_prio_select #(.N(NUM_SRC), .IDX_W(IDX_W)) u_sel_service (
        .member    (st_q.service),
        .prio_flat (src_prio),
        .found     (sv_found),
        .idx       (sv_idx),
        .best      (sv_best)
    );

    always_comb begin
        aligned = (reg_addr[3:0] == 4'h0);
        hit_tpr = aligned && (reg_addr == ADDR_W'(OFS_TPR));
        hit_ack = aligned && (reg_addr == ADDR_W'(OFS_ACK));
        hit_eoi = aligned && (reg_addr == ADDR_W'(OFS_EOI));

        tpr_wr  = reg_wr && hit_tpr;
        eoi_wr  = reg_wr && hit_eoi;
        ack_rd  = reg_rd && hit_ack;
        ack_ok  = ack_rd && rs_found && (rs_best > st_q.tpr);
        ack_clr = ack_ok ? (NUM_SRC'(1) << rs_idx) : '0;
        rs_vec  = src_vec[rs_idx*VEC_W +: VEC_W];

        st_d = st_q;

        if (tpr_wr) begin
            st_d.tpr = reg_wdata[PRIO_W-1:0];
        end

        if (ack_ok) begin
            st_d.service = st_q.service | ack_clr;
        end else if (eoi_wr && sv_found) begin
            st_d.service = st_q.service & ~(NUM_SRC'(1) << sv_idx);
        end

        if (reg_rd) begin
            if (!aligned)     st_d.rdata = '1;
            else if (hit_tpr) st_d.rdata = DATA_W'(st_q.tpr);
            else if (hit_ack) st_d.rdata = DATA_W'(ack_ok ? rs_vec : SPURIOUS);
            else if (hit_eoi) st_d.rdata = '0;
            else              st_d.rdata = '1;
        end

        st_d.irq = rs_found && (rs_best > st_q.tpr) &&
                   (!sv_found || rs_best > sv_best) && !ack_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tpr     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign irq_out   = st_q.irq;

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFS_ACK)) |=> !irq_out); // R4
    AST_ACK_INTO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> st_q.service[$past(rs_idx)]); // R4
    AST_SPURIOUS_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !ack_ok) |=> $stable(st_q.service)); // R5
    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && sv_found) |=>
        $countones(st_q.service) == $past($countones(st_q.service)) - 1); // R7
    AST_MISALIGNED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[3:0] != 4'h0) |=> $stable(st_q.tpr)); // R9
    AST_IRQ_NEEDS_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(rs_found)); // R2
    AST_IRQ_ABOVE_TPR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(rs_best > st_q.tpr)); // R2
endmodule

// File: tb/sim_irq_delivery_unit.sv
module sim_irq_delivery_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 8;
    localparam int VW     = 8;
    localparam int AW     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      src_req = '0;
    logic [N-1:0]      src_edge = '0;
    logic [N*4-1:0]    src_prio = '0;
    logic [N*VW-1:0]   src_vec;
    logic [AW-1:0]     reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_vec
        assign src_vec[g*VW +: VW] = VW'(8'h40 + g);
    end

    irq_delivery_unit #(.NUM_SRC(N), .VEC_W(VW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_edge(src_edge),
        .src_prio(src_prio), .src_vec(src_vec), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // monitor: read data is due one edge after the strobe (R10)
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                fails++;
                $display("FAIL %s read: got %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input int a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_addr = AW'(a); reg_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_out !== e) begin
            fails++;
            $display("FAIL %s irq_out: got %b expected %b", t, irq_out, e);
        end
    endtask

    task automatic set_src(input int i, input logic r, input logic ed, input int p);
        @(negedge clk);
        src_prio[i*4 +: 4] = 4'(p);
        src_edge[i] = ed;
        src_req[i]  = r;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // reset state
        chk_irq(1'b0, "R2 reset");
        do_read('h80, 32'h0000000F, "R3 tpr reset");
        do_read('hB0, 32'h0, "R9 eoi read");
        do_read('h81, 32'hFFFFFFFF, "R9 misaligned read");
        do_read('h40, 32'hFFFFFFFF, "R9 unmapped read");
        do_read('hA0, 32'h000000FF, "R5 ack empty");

        // level source 3 prio 5 blocked by tpr 15
        set_src(3, 1'b1, 1'b0, 5);
        settle();
        chk_irq(1'b0, "R3 tpr 15 blocks");
        do_write('h80, 32'h34);
        do_read('h80, 32'h4, "R3 low bits kept");
        settle();
        chk_irq(1'b1, "R8 tpr lowered");
        do_write('h80, 32'h5);
        settle();
        chk_irq(1'b0, "R8 tpr equal blocks");
        do_write('h80, 32'h2);
        settle();
        chk_irq(1'b1, "R8 tpr re-raise");

        // acknowledge level source
        do_read('hA0, 32'h43, "R4 ack vector");
        chk_irq(1'b0, "R4 irq drops");
        settle();
        chk_irq(1'b0, "R6 level in service blocked");

        // equal priority blocked, higher nests
        set_src(1, 1'b1, 1'b0, 5);
        settle();
        chk_irq(1'b0, "R2 equal blocked");
        set_src(6, 1'b1, 1'b0, 9);
        settle();
        chk_irq(1'b1, "R2 higher nests");
        do_read('hA0, 32'h46, "R4 nested ack");
        do_write('hB0, 32'h0);
        settle();
        chk_irq(1'b1, "R7 level re-raised after eoi");
        set_src(6, 1'b0, 1'b0, 9);
        settle();
        chk_irq(1'b0, "R2 tie with service");
        do_write('hB0, 32'h0);
        settle();
        chk_irq(1'b1, "R7 empty service");
        do_read('hA0, 32'h41, "R1 tie lowest index");
        settle();
        chk_irq(1'b0, "R4 after tie ack");
        set_src(1, 1'b0, 1'b0, 5);
        set_src(3, 1'b0, 1'b0, 5);
        do_write('hB0, 32'h0);
        settle();
        chk_irq(1'b0, "R7 drained");

        // edge source
        set_src(2, 1'b1, 1'b1, 7);
        set_src(2, 1'b0, 1'b1, 7);
        settle();
        chk_irq(1'b1, "R6 edge latched");
        do_read('hA0, 32'h42, "R6 edge ack");
        do_read('hA0, 32'h000000FF, "R6 edge consumed");
        do_write('hB0, 32'h0);
        settle();
        chk_irq(1'b0, "R6 edge gone");

        // retirement order: highest in service first
        do_write('h80, 32'h0);
        set_src(4, 1'b1, 1'b0, 3);
        settle();
        do_read('hA0, 32'h44, "R4 first of pair");
        set_src(5, 1'b1, 1'b0, 8);
        settle();
        chk_irq(1'b1, "R2 nest over 3");
        do_read('hA0, 32'h45, "R4 second of pair");
        set_src(4, 1'b0, 1'b0, 3);
        settle();
        chk_irq(1'b0, "R7 before eoi");
        do_write('hB0, 32'h0);
        settle();
        chk_irq(1'b1, "R7 highest retired first");
        set_src(5, 1'b0, 1'b0, 8);
        do_write('hB0, 32'h0);
        do_write('hB0, 32'h0);
        settle();
        chk_irq(1'b0, "R7 empty eoi harmless");

        // spurious when raised but not above tpr
        do_write('h80, 32'hA);
        set_src(4, 1'b1, 1'b0, 8);
        settle();
        chk_irq(1'b0, "R5 below tpr");
        do_read('hA0, 32'h000000FF, "R5 ack below tpr");
        do_write('h84, 32'h0);
        do_read('h80, 32'hA, "R9 misaligned write ignored");
        do_write('h80, 32'h7);
        settle();
        chk_irq(1'b1, "R5 service unchanged by spurious");

        settle();
        summary();
    end
endmodule